// File: doc/BRIEF.md
# Asynchronous Byte-Memory Read Strobe Controller

This block sits on the host side of a bus that carries several asynchronous byte-wide read-only memories. A request together with a full address starts one read. The upper address bits pick a single device and drive that device's active-low chip select. The lower bits go out as the memory address. The shared active-low output enable, which stands for the system read strobe, is asserted only after the chip select has led it long enough. The returned byte is captured once the full access time has passed and is handed back with a one-cycle valid pulse. Both strobes are then released together. A float window follows, and no device is selected again until the previous one has had time to release the data bus.

All three timing figures are given in nanoseconds together with the clock period. Each is rounded up to whole clock cycles. With a 4 ns clock the 45 ns access time becomes 12 cycles, the 25 ns output-enable delay becomes 7 cycles and the 17 ns float time becomes 5 cycles. Chip select therefore leads output enable by 12 - 7 = 5 cycles.

The sequencer has four states:
- `ST_IDLE` waits for a request. Its transition *accept* (request while idle) moves to `ST_SELECT`.
- `ST_SELECT` drives the address and the chip select. Its transition *lead_done* moves to `ST_STROBE`.
- `ST_STROBE` adds output enable. Its transition *capture* samples the data and moves to `ST_FLOAT`.
- `ST_FLOAT` holds both strobes high. Its transition *float_done* returns to `ST_IDLE`.

Top module: `rdc_strobe_ctrl`

## Requirements
- R1: While reset is low, and in the cycle after reset is applied, every `mem_ce_n` bit and `mem_oe_n` are 1, `busy` and `rd_valid` are 0, and `rd_data` is 0. This holds even when reset arrives in the middle of a read.
- R2: A request is accepted at a clock edge where `req` is 1 and `busy` is 0. In the cycle after acceptance, `mem_addr` equals `req_addr[15:0]`. The device index is `req_addr[17:16]`. Bit i of `mem_ce_n` is 0 exactly when device i is selected, and all other bits are 1.
- R3: `mem_oe_n` goes low only while a chip select is low. It goes low after chip select has been low for 5 cycles and then stays low for 7 cycles.
- R4: `rd_valid` is high for exactly one cycle. That cycle starts 12 cycles after the acceptance edge, and in it `rd_data` carries the byte present on `mem_dq` at the end of the 12th chip-select cycle.
- R5: In the cycle where `rd_valid` is high, all chip selects and output enable are already high. After that, no chip select goes low again for at least 5 cycles.
- R6: `busy` is high from the cycle after acceptance through the last float cycle, which is 12 + 5 = 17 cycles. It falls in the cycle after that.
- R7: A request made while `busy` is high is ignored. `mem_addr`, the selected chip select and the returned byte all belong to the read already in progress, and `busy` stays low after that read ends.
- R8: A request held high through the last float cycle is not taken at that edge. It is taken at the next edge, so the second read's chip select goes low 18 cycles after the first acceptance.
- R9: `rd_data` keeps its value between valid pulses, including throughout the following read up to that read's capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, taken when `busy` is low |
| req_addr | input | 18 | Device index in bits 17:16, byte address in bits 15:0 |
| busy | output | 1 | High from acceptance until the float window ends |
| rd_valid | output | 1 | One-cycle pulse marking a captured byte |
| rd_data | output | 8 | Last captured byte |
| mem_addr | output | 16 | Address driven to the memories |
| mem_ce_n | output | 4 | Active-low chip select, one bit per device |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq | input | 8 | Data bus returned by the memories |

## Verification
Two events can meet in the same cycle: the *float_done* transition and a new request. To provoke this, the bench raises `req` with a fresh address in the last float cycle and keeps it high. It then checks that `busy` is still high at that edge, that the request is refused there, and that it is taken at the next edge. The chip select of the second device must appear exactly 18 cycles after the first acceptance, never sooner. The bench's memory model returns the inverted byte unless chip select and output enable have been low for their full access windows. A capture made a cycle too early therefore shows up as a wrong byte, and one made too late shows up as a wrong valid cycle.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SELECT = 2'd1,
        ST_STROBE = 2'd2,
        ST_FLOAT  = 2'd3
    } rdc_state_e;

    // Round a time in ns up to whole clock cycles, never below one cycle.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rdc_timer.sv
module rdc_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/rdc_cs_decode.sv
module rdc_cs_decode #(
    parameter int SEL_W = 2,
    localparam int NDEV = 1 << SEL_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [NDEV-1:0]  ce_n
);
    for (genvar i = 0; i < NDEV; i++) begin : g_dev
        assign ce_n[i] = !(en && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/rdc_seq.sv
module rdc_seq
    import rdc_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int LEAD_CYC = 5,
    parameter int OE_CYC   = 7,
    parameter int DF_CYC   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             tmr_done,
    output logic             accept,
    output logic             capture,
    output logic             busy,
    output logic             ce_en,
    output logic             oe_n,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);
    localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] OE_LD   = CNT_W'(OE_CYC - 1);
    localparam logic [CNT_W-1:0] DF_LD   = CNT_W'(DF_CYC - 1);

    rdc_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state, transition events and outputs
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        capture  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        busy     = 1'b1;
        ce_en    = 1'b0;
        oe_n     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (req) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LEAD_LD;
                    state_d  = ST_SELECT;
                end
            end
            ST_SELECT: begin
                ce_en = 1'b1;
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = OE_LD;
                    state_d  = ST_STROBE;
                end
            end
            ST_STROBE: begin
                ce_en = 1'b1;
                oe_n  = 1'b0;
                if (tmr_done) begin
                    capture  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = DF_LD;
                    state_d  = ST_FLOAT;
                end
            end
            ST_FLOAT: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end
endmodule

// File: rtl/rdc_strobe_ctrl.sv
module rdc_strobe_ctrl
    import rdc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 2,
    parameter int DATA_W = 8,
    parameter int CLK_NS = 4,
    parameter int ACC_NS = 45,
    parameter int OE_NS  = 25,
    parameter int DF_NS  = 17,
    localparam int NDEV   = 1 << SEL_W,
    localparam int FULL_W = ADDR_W + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [FULL_W-1:0] req_addr,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NDEV-1:0]   mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_dq
);
    localparam int ACC_CYC  = ns_to_cycles(ACC_NS, CLK_NS);
    localparam int OE_CYC   = ns_to_cycles(OE_NS, CLK_NS);
    localparam int DF_CYC   = ns_to_cycles(DF_NS, CLK_NS);
    localparam int LEAD_CYC = (ACC_CYC > OE_CYC) ? (ACC_CYC - OE_CYC) : 1;
    localparam int CNT_W    = $clog2(max3(LEAD_CYC, OE_CYC, DF_CYC) + 1);

    logic             accept;
    logic             capture;
    logic             ce_en;
    logic             tmr_load;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic [SEL_W-1:0] dev_q;
    logic [ADDR_W-1:0] addr_q;

    rdc_seq #(
        .CNT_W    (CNT_W),
        .LEAD_CYC (LEAD_CYC),
        .OE_CYC   (OE_CYC),
        .DF_CYC   (DF_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .tmr_done (tmr_done),
        .accept   (accept),
        .capture  (capture),
        .busy     (busy),
        .ce_en    (ce_en),
        .oe_n     (mem_oe_n),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val)
    );

    rdc_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    rdc_cs_decode #(
        .SEL_W (SEL_W)
    ) u_dec (
        .en   (ce_en),
        .sel  (dev_q),
        .ce_n (mem_ce_n)
    );

    // Request latch: address and device index held for the whole cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_q  <= '0;
            addr_q <= '0;
        end else if (accept) begin
            dev_q  <= req_addr[FULL_W-1:ADDR_W];
            addr_q <= req_addr[ADDR_W-1:0];
        end
    end

    assign mem_addr = addr_q;

    // Data capture and valid pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= mem_dq;
            end
        end
    end
endmodule

// File: rtl/rdc_strobe_chk.sv
module rdc_strobe_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int NDEV   = 4,
    parameter int DF_CYC = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              busy,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NDEV-1:0]   mem_ce_n,
    input logic              mem_oe_n
);
    logic [7:0] high_run;
    logic       seen_read;
    logic       all_high;

    assign all_high = &mem_ce_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_run  <= '0;
            seen_read <= 1'b0;
        end else begin
            if (!all_high) begin
                high_run  <= '0;
                seen_read <= 1'b1;
            end else if (high_run != 8'hFF) begin
                high_run <= high_run + 1'b1;
            end
        end
    end

    // R2: at most one device selected
    p_single_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ce_n));

    // R2: a read starts with exactly one chip select low
    p_select_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($countones(~mem_ce_n) == 1));

    // R3: output enable only under an active chip select
    p_oe_under_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !all_high);

    // R4: valid lasts one cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R5: strobes released by the time data is returned
    p_release_at_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (all_high && mem_oe_n));

    // R5: float gap before reselecting
    p_float_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_read && !all_high && $past(all_high)) |-> (int'(high_run) >= DF_CYC));

    // R6: strobes and valid only inside busy
    p_busy_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_high || rd_valid) |-> busy);

    // R7: address steady while a device is selected
    p_addr_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_high && !$past(all_high)) |-> $stable(mem_addr));

    // R8: an idle request is taken
    p_idle_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);

    // R9: data holds between pulses
    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));
endmodule

bind rdc_strobe_ctrl rdc_strobe_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NDEV   (NDEV),
    .DF_CYC (DF_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .busy     (busy),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n)
);

// File: tb/rdc_strobe_ctrl_test.sv
module rdc_strobe_ctrl_test;
    localparam int ACC  = 12;
    localparam int OEC  = 7;
    localparam int DF   = 5;
    localparam int LEAD = ACC - OEC;
    localparam int NVEC = 8;

    localparam logic [17:0] VEC_ADDR [NVEC] = '{
        18'h0_0000, 18'h0_FFFF, 18'h1_1234, 18'h2_8001,
        18'h3_C0DE, 18'h1_00FF, 18'h3_FFFF, 18'h2_0000
    };
    localparam logic [3:0] VEC_CE [NVEC] = '{
        4'b1110, 4'b1110, 4'b1101, 4'b1011,
        4'b0111, 4'b1101, 4'b0111, 4'b1011
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [17:0] req_addr = '0;
    logic        busy;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [15:0] mem_addr;
    logic [3:0]  mem_ce_n;
    logic        mem_oe_n;
    logic [7:0]  mem_dq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] prev_data = 8'h00;

    always #2 clk = ~clk;

    rdc_strobe_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_addr (req_addr),
        .busy     (busy),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .mem_addr (mem_addr),
        .mem_ce_n (mem_ce_n),
        .mem_oe_n (mem_oe_n),
        .mem_dq   (mem_dq)
    );

    function automatic logic [7:0] pattern(input logic [1:0] dev, input logic [15:0] a);
        return (a[7:0] + a[15:8]) ^ {dev, 6'b101001};
    endfunction

    // Memory model: correct byte only after full access windows
    int ce_run = 0;
    int oe_run = 0;
    always_ff @(posedge clk) begin
        ce_run <= (&mem_ce_n) ? 0 : ce_run + 1;
        oe_run <= mem_oe_n ? 0 : oe_run + 1;
    end

    always_comb begin
        logic [1:0] dev;
        dev = 2'd0;
        for (int i = 0; i < 4; i++) begin
            if (!mem_ce_n[i]) dev = 2'(i);
        end
        if (!(&mem_ce_n) && !mem_oe_n && ce_run >= ACC - 1 && oe_run >= OEC - 1)
            mem_dq = pattern(dev, mem_addr);
        else
            mem_dq = ~pattern(dev, mem_addr);
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check({mem_ce_n, mem_oe_n, rd_valid, busy} == 7'b1111_1_0_0, tag,
              32'({mem_ce_n, mem_oe_n, rd_valid, busy}), 32'h7C);
    endtask

    // Entered at a negedge with busy low; leaves at the first idle negedge.
    task automatic run_read(input logic [17:0] a, input logic [3:0] ce_exp,
                            input bit intrude, input bit chain,
                            input logic [17:0] next_a);
        logic [7:0] exp_d;
        logic [6:0] exp_t;
        logic [6:0] got_t;
        exp_d = pattern(a[17:16], a[15:0]);
        req = 1'b1;
        req_addr = a;
        for (int n = 1; n <= ACC + DF + 1; n++) begin
            @(negedge clk);
            exp_t = {((n <= ACC) ? ce_exp : 4'hF),
                     !(n >= LEAD + 1 && n <= ACC),
                     (n == ACC + 1),
                     (n <= ACC + DF)};
            got_t = {mem_ce_n, mem_oe_n, rd_valid, busy};
            check(got_t == exp_t, $sformatf("R2 R3 R5 R6 strobes n=%0d", n),
                  32'(got_t), 32'(exp_t));
            if (n == 1)
                check(mem_addr == a[15:0], "R2 address", 32'(mem_addr), 32'(a[15:0]));
            if (n == ACC)
                check(mem_addr == a[15:0], "R7 address held", 32'(mem_addr), 32'(a[15:0]));
            if (n <= ACC)
                check(rd_data == prev_data, $sformatf("R9 hold n=%0d", n),
                      32'(rd_data), 32'(prev_data));
            if (n == ACC + 1)
                check(rd_data == exp_d, "R4 data", 32'(rd_data), 32'(exp_d));
            if (n == ACC + DF + 1 && chain)
                check(busy == 1'b0 && (&mem_ce_n), "R8 held request refused at float end",
                      32'({busy, mem_ce_n}), 32'h0F);
            // drive
            if (n == 1) req = 1'b0;
            if (intrude && n == 2) begin
                req = 1'b1;
                req_addr = ~a;
            end
            if (intrude && n == 5) begin
                req = 1'b0;
                req_addr = a;
            end
            if (chain && n == ACC + DF) begin
                req = 1'b1;
                req_addr = next_a;
            end
        end
        prev_data = exp_d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_idle("R1 reset outputs");
        check(rd_data == 8'h00, "R1 reset data", 32'(rd_data), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after release");

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            run_read(VEC_ADDR[v], VEC_CE[v], 1'b0, 1'b0, '0);
        end

        // R7: request during busy is ignored
        run_read(18'h1_5A5A, 4'b1101, 1'b1, 1'b0, '0);
        @(negedge clk);
        check(busy == 1'b0 && (&mem_ce_n), "R7 no stray acceptance",
              32'({busy, mem_ce_n}), 32'h0F);

        // R8: request held across the final float cycle
        run_read(18'h2_1357, 4'b1011, 1'b0, 1'b1, 18'h3_2468);
        run_read(18'h3_2468, 4'b0111, 1'b0, 1'b0, '0);

        // R9: data held while idle
        repeat (6) @(negedge clk);
        check(rd_data == prev_data, "R9 idle hold", 32'(rd_data), 32'(prev_data));
        check_idle("R6 idle after read");

        // R1: reset in the middle of a read
        req = 1'b1;
        req_addr = 18'h0_4444;
        @(negedge clk);
        req = 1'b0;
        repeat (LEAD + 2) @(negedge clk);
        check(mem_oe_n == 1'b0, "R3 strobe before reset", 32'(mem_oe_n), 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 reset mid read");
        check(rd_data == 8'h00, "R1 reset mid read data", 32'(rd_data), 32'h0);
        rst_n = 1'b1;
        prev_data = 8'h00;
        @(negedge clk);
        run_read(18'h0_4444, 4'b1110, 1'b0, 1'b0, '0);

        finish_run();
    end
endmodule